// File: doc/BRIEF.md
# Gated Programmable Interval Timer

This block is one 16-bit timer channel running on the bus clock. Software configures it through three registers (control, count and compare value) over a single-cycle write port with a combinational read port. The count advances on one of three prescaled rates of the bus clock, or once per horizontal-blank pulse. It raises sticky flags on a compare match and on a wrap past the top of the range, and sends a one-cycle interrupt pulse for each flag event whose interrupt is enabled.

A gate input can start, stop or restart the count from video timing. Either the horizontal-blank or the vertical-blank signal can act as the gate, and four behaviours are available. Both blank inputs are asynchronous. They are synchronised inside the block and edge-detected, so each gate start (rising edge), gate end (falling edge) and horizontal-blank clock tick acts once. Register select codes: 0 is control, 1 is count, 2 is compare. A read with select 3 returns zero.

Top module: `gated_interval_timer`

## Requirements
- R1: When an increment takes the count past 0xFFFF, the count becomes 0 and control bit 11 (wrap flag) is set. An interrupt pulse is issued only if control bit 9 is 1.
- R2: Control bits [1:0] pick the count rate. 0 gives one step every 2 bus clocks, 1 every 32, 2 every 512, and 3 gives one step per rising edge of the horizontal-blank input.
- R3: Control bit 7 is the run bit. While it is 0, the count keeps its value.
- R4: When an increment makes the count equal to the compare value and control bit 8 is 1, control bit 10 (match flag) is set and an interrupt pulse is issued. If bit 8 is 0, neither happens.
- R5: On a match, the count returns to 0 only when control bits 6 and 8 are both 1. Otherwise counting carries on past the compare value.
- R6: A control write replaces bits [9:0]. Flag bits 10 and 11 clear only where the written value holds a 1, and otherwise keep their value.
- R7: Control bit 2 turns the gate on, and bit 3 picks its source (0 horizontal blank, 1 vertical blank). A control write that turns the gate on zeroes the count and clears the run bit. Edges on the unselected blank input have no effect.
- R8: Gate behaviour 0 (bits [5:4] = 0): the run bit clears at each gate start and sets at each gate end, so the count advances only while the gate is low.
- R9: Gate behaviour 1 zeroes the count and sets the run bit at gate start, behaviour 2 does so at gate end, and behaviour 3 does so at both. An edge of the other kind leaves the count running.
- R10: When control bits [3:0] are 0111, the gate is off. Such a control write neither zeroes the count nor stops it.
- R11: A count write loads the value. A match happens only on an increment that reaches the compare value, so a compare value at or below the count cannot match until the count has wrapped.
- R12: The interrupt output is high for exactly one clock per event. Whenever it is high, at least one flag bit reads as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrSel | input | 2 | Write target: 0 control, 1 count, 2 compare |
| wrData | input | 16 | Write data |
| rdSel | input | 2 | Read select, same codes as wrSel |
| rdData | output | 16 | Read data, combinational |
| hblankIn | input | 1 | Horizontal-blank level, asynchronous |
| vblankIn | input | 1 | Vertical-blank level, asynchronous |
| irqOut | output | 1 | Interrupt pulse |

## Verification
The assertions assume that the blank inputs, once synchronised, never produce a rising and a falling edge in the same cycle, and that register writes are single-cycle strobes that do not coincide with a gate edge. The stimulus holds every blank level for at least three clocks and issues each register write alone, followed by enough idle clocks for the synchronisers to settle before anything is sampled. Count rates are measured as the difference between two reads taken an exact number of clocks apart, so the result does not depend on the prescaler phase.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int MODE_W = 12;

  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_COUNT  = 2'd1;
  localparam logic [1:0] SEL_TARGET = 2'd2;

  localparam int BIT_GATE_EN  = 2;
  localparam int BIT_GATE_SRC = 3;
  localparam int BIT_ZRET     = 6;
  localparam int BIT_RUN      = 7;
  localparam int BIT_EQ_IE    = 8;
  localparam int BIT_OVF_IE   = 9;
  localparam int BIT_EQ_FLAG  = 10;
  localparam int BIT_OVF_FLAG = 11;

  localparam logic [3:0] GATE_OFF_CODE = 4'b0111;

  typedef struct packed {
    logic tick;   // advance the count by one
    logic clear;  // force the count to zero
  } tmr_stb_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int DIV_LOG0    = 1,
  parameter int DIV_LOG1    = 5,
  parameter int DIV_LOG2    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrMode,
  input  logic [MODE_W-1:0] wrData,
  input  logic              hblankIn,
  input  logic              vblankIn,
  input  logic              eqHit,
  input  logic              ovfHit,
  output logic [MODE_W-1:0] modeQ,
  output tmr_stb_t          stb,
  output logic              rstOnMatch,
  output logic              irqOut
);
  localparam int PRE_W = DIV_LOG2;

  // input synchronisers and edge detectors
  logic [SYNC_STAGES-1:0] hShift, vShift;
  logic hPrev, vPrev;
  logic hNow, vNow, hRise, hFall, vRise, vFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hShift <= '0;
      vShift <= '0;
      hPrev  <= 1'b0;
      vPrev  <= 1'b0;
    end else begin
      hShift <= {hShift[SYNC_STAGES-2:0], hblankIn};
      vShift <= {vShift[SYNC_STAGES-2:0], vblankIn};
      hPrev  <= hShift[SYNC_STAGES-1];
      vPrev  <= vShift[SYNC_STAGES-1];
    end
  end

  assign hNow  = hShift[SYNC_STAGES-1];
  assign vNow  = vShift[SYNC_STAGES-1];
  assign hRise = hNow & ~hPrev;
  assign hFall = ~hNow & hPrev;
  assign vRise = vNow & ~vPrev;
  assign vFall = ~vNow & vPrev;

  // free-running prescaler, restarted when the rate field changes
  logic [PRE_W-1:0] preQ;
  logic selChange, srcTick;

  assign selChange = wrMode && (wrData[1:0] != modeQ[1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          preQ <= '0;
    else if (selChange) preQ <= '0;
    else                preQ <= preQ + 1'b1;
  end

  always_comb begin
    unique case (modeQ[1:0])
      2'd0:    srcTick = &preQ[DIV_LOG0-1:0];
      2'd1:    srcTick = &preQ[DIV_LOG1-1:0];
      2'd2:    srcTick = &preQ;
      default: srcTick = hRise;
    endcase
  end

  // gate decode
  logic gateOn, gStart, gEnd, runSet, runClr, gateRst, wrGate;

  assign gateOn = modeQ[BIT_GATE_EN] && (modeQ[3:0] != GATE_OFF_CODE);
  assign gStart = modeQ[BIT_GATE_SRC] ? vRise : hRise;
  assign gEnd   = modeQ[BIT_GATE_SRC] ? vFall : hFall;
  assign wrGate = wrData[BIT_GATE_EN] && (wrData[3:0] != GATE_OFF_CODE);

  always_comb begin
    runSet  = 1'b0;
    runClr  = 1'b0;
    gateRst = 1'b0;
    if (gateOn) begin
      unique case (modeQ[5:4])
        2'd0: begin runClr = gStart; runSet = gEnd; end
        2'd1: begin runSet = gStart; gateRst = gStart; end
        2'd2: begin runSet = gEnd; gateRst = gEnd; end
        default: begin runSet = gStart | gEnd; gateRst = gStart | gEnd; end
      endcase
    end
  end

  // control register
  logic [MODE_W-1:0] modeNext;

  always_comb begin
    modeNext = modeQ;
    if (wrMode) begin
      modeNext = {modeQ[BIT_OVF_FLAG:BIT_EQ_FLAG] & ~wrData[BIT_OVF_FLAG:BIT_EQ_FLAG],
                  wrData[BIT_OVF_IE:0]};
      if (wrGate) modeNext[BIT_RUN] = 1'b0;
    end else begin
      if (runSet) modeNext[BIT_RUN] = 1'b1;
      if (runClr) modeNext[BIT_RUN] = 1'b0;
    end
    if (eqHit && modeQ[BIT_EQ_IE]) modeNext[BIT_EQ_FLAG] = 1'b1;
    if (ovfHit)                    modeNext[BIT_OVF_FLAG] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      irqOut <= 1'b0;
    end else begin
      modeQ  <= modeNext;
      irqOut <= (eqHit && modeQ[BIT_EQ_IE]) || (ovfHit && modeQ[BIT_OVF_IE]);
    end
  end

  assign stb.tick   = modeQ[BIT_RUN] && srcTick;
  assign stb.clear  = wrMode ? wrGate : gateRst;
  assign rstOnMatch = modeQ[BIT_ZRET] && modeQ[BIT_EQ_IE];

  // R6: flags are sticky unless a written one clears them
  p_eq_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeQ[BIT_EQ_FLAG] && !(wrMode && wrData[BIT_EQ_FLAG]) |=> modeQ[BIT_EQ_FLAG]);
  p_ovf_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeQ[BIT_OVF_FLAG] && !(wrMode && wrData[BIT_OVF_FLAG]) |=> modeQ[BIT_OVF_FLAG]);
  // R12: an interrupt pulse is always backed by a flag
  p_irq_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (modeQ[BIT_EQ_FLAG] || modeQ[BIT_OVF_FLAG]));
  // R10: the disabled-gate code never zeroes the count
  p_gate_off_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[3:0] == GATE_OFF_CODE) && !wrMode |-> !stb.clear);
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_stb_t         stb,
  input  logic             wrCount,
  input  logic             wrTarget,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rstOnMatch,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] targetQ,
  output logic             eqHit,
  output logic             ovfHit
);
  logic [CNT_W:0] nxt;
  logic live;

  assign nxt    = {1'b0, countQ} + 1'b1;
  assign live   = stb.tick && !wrCount && !stb.clear;
  assign eqHit  = live && (nxt[CNT_W-1:0] == targetQ);
  assign ovfHit = live && nxt[CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ  <= '0;
      targetQ <= '1;
    end else begin
      if (wrTarget) targetQ <= wrData;
      if (wrCount)        countQ <= wrData;
      else if (stb.clear) countQ <= '0;
      else if (stb.tick)  countQ <= (eqHit && rstOnMatch) ? '0 : nxt[CNT_W-1:0];
    end
  end

  // R1: increment from the top of the range lands on zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == '1) && stb.tick && !wrCount && !stb.clear |=> countQ == '0);
  // R5: without return-to-zero a match leaves the count on the compare value
  p_match_continue_r5: assert property (@(posedge clk) disable iff (!rstN)
    eqHit && !rstOnMatch && !wrTarget |=> countQ == $past(targetQ));
endmodule

// File: rtl/gated_interval_timer.sv
module gated_interval_timer
  import timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_LOG0    = 1,
  parameter int DIV_LOG1    = 5,
  parameter int DIV_LOG2    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdSel,
  output logic [CNT_W-1:0] rdData,
  input  logic             hblankIn,
  input  logic             vblankIn,
  output logic             irqOut
);
  localparam int PAD_W = CNT_W - MODE_W;

  logic [MODE_W-1:0] modeQ;
  logic [CNT_W-1:0]  countQ, targetQ;
  tmr_stb_t          stb;
  logic              eqHit, ovfHit, rstOnMatch;
  logic              wrMode, wrCount, wrTarget;

  assign wrMode   = wrEn && (wrSel == SEL_MODE);
  assign wrCount  = wrEn && (wrSel == SEL_COUNT);
  assign wrTarget = wrEn && (wrSel == SEL_TARGET);

  timer_ctrl #(
    .DIV_LOG0(DIV_LOG0), .DIV_LOG1(DIV_LOG1), .DIV_LOG2(DIV_LOG2), .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrMode(wrMode), .wrData(wrData[MODE_W-1:0]),
    .hblankIn(hblankIn), .vblankIn(vblankIn), .eqHit(eqHit), .ovfHit(ovfHit),
    .modeQ(modeQ), .stb(stb), .rstOnMatch(rstOnMatch), .irqOut(irqOut)
  );

  timer_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrCount(wrCount), .wrTarget(wrTarget),
    .wrData(wrData), .rstOnMatch(rstOnMatch), .countQ(countQ), .targetQ(targetQ),
    .eqHit(eqHit), .ovfHit(ovfHit)
  );

  always_comb begin
    unique case (rdSel)
      SEL_MODE:   rdData = {{PAD_W{1'b0}}, modeQ};
      SEL_COUNT:  rdData = countQ;
      SEL_TARGET: rdData = targetQ;
      default:    rdData = '0;
    endcase
  end

  // R3: with the run bit clear the count only moves by a write or a gate restart
  p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ[BIT_RUN] && !stb.clear && !wrCount |=> $stable(countQ));
endmodule

// File: tb/test_gated_interval_timer.sv
`timescale 1ns/1ps
module test_gated_interval_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic [1:0]  rdSel = 2'd0;
  logic [15:0] rdData;
  logic        hblankIn = 1'b0;
  logic        vblankIn = 1'b0;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  int irqCnt = 0;
  int irqWide = 0;
  logic irqPrev = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gated_interval_timer i_gated_interval_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .hblankIn(hblankIn), .vblankIn(vblankIn),
    .irqOut(irqOut)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (irqOut) irqCnt++;
      if (irqOut && irqPrev) irqWide++;
      irqPrev = irqOut;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = s; wrData = d[15:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output int v);
    rdSel = s;
    #1;
    v = int'(rdData);
  endtask

  task automatic hPulse();
    hblankIn = 1'b1; waitc(3);
    hblankIn = 1'b0; waitc(3);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int v, c0, c1, base;
    waitc(3);
    rstN = 1'b1;
    waitc(2);

    // reset state
    rd(2'd0, v); chk("R6 reset control", v == 0, v, 0);
    rd(2'd1, v); chk("R3 reset count", v == 0, v, 0);
    chk("R12 reset irq", irqOut == 1'b0, int'(irqOut), 0);

    // R3: stopped count holds
    wr(2'd1, 123);
    rd(2'd1, c0); waitc(40); rd(2'd1, c1);
    chk("R3 stopped hold", c1 == 123 && c0 == 123, c1, 123);

    // R2: prescaled rates, measured over an exact window
    for (int sel = 0; sel < 3; sel++) begin
      int div;
      div = (sel == 0) ? 2 : (sel == 1) ? 32 : 512;
      wr(2'd0, 'h80 | sel);
      waitc(3);
      rd(2'd1, c0); waitc(5 * div); rd(2'd1, c1);
      chk($sformatf("R2 rate sel%0d", sel), ((c1 - c0) & 'hFFFF) == 5, (c1 - c0) & 'hFFFF, 5);
    end
    // R2: horizontal-blank clock
    wr(2'd0, 'h83);
    rd(2'd1, c0);
    for (int i = 0; i < 7; i++) hPulse();
    waitc(4);
    rd(2'd1, c1);
    chk("R2 hblank clock", ((c1 - c0) & 'hFFFF) == 7, (c1 - c0) & 'hFFFF, 7);

    // R3: clearing run bit stops a running count
    wr(2'd0, 'h00);
    rd(2'd1, c0); waitc(30); rd(2'd1, c1);
    chk("R3 stop freezes", c1 == c0, c1, c0);

    // R1: wrap with interrupt enabled
    wr(2'd0, 'hC00); wr(2'd1, 'hFFFA); wr(2'd2, 'h1234);
    base = irqCnt;
    wr(2'd0, 'h280);
    rd(2'd1, c0); waitc(20); rd(2'd1, c1);
    chk("R1 wrap value", c1 == ((c0 + 10) & 'hFFFF), c1, (c0 + 10) & 'hFFFF);
    rd(2'd0, v); chk("R1 wrap flag", v[11] == 1'b1, v[11], 1);
    chk("R1 wrap irq", irqCnt - base == 1, irqCnt - base, 1);

    // R1: wrap with interrupt disabled
    wr(2'd0, 'hC00); wr(2'd1, 'hFFFA);
    rd(2'd0, v); chk("R6 flag cleared by write", v[11] == 1'b0, v[11], 0);
    base = irqCnt;
    wr(2'd0, 'h080);
    waitc(20);
    rd(2'd0, v); chk("R1 flag without irq enable", v[11] == 1'b1, v[11], 1);
    chk("R1 no irq when disabled", irqCnt == base, irqCnt - base, 0);

    // R6: writes without ones in the flag positions keep the flags
    wr(2'd0, 'h080);
    rd(2'd0, v); chk("R6 flag kept", v[11] == 1'b1, v[11], 1);
    wr(2'd0, 'h802);
    rd(2'd0, v); chk("R6 replace and clear", v == 'h002, v, 'h002);

    // R4/R5: compare sweep over match-enable and return-to-zero
    for (int cfg = 0; cfg < 4; cfg++) begin
      bit zret, eqie;
      int cm, expV, m;
      zret = cfg[0];
      eqie = cfg[1];
      cm = (zret ? 'h40 : 0) | (eqie ? 'h100 : 0);
      wr(2'd0, 'hC00 | cm); wr(2'd1, 0); wr(2'd2, 20);
      base = irqCnt;
      wr(2'd0, 'h80 | cm);
      rd(2'd1, c0);
      expV = c0; m = 0;
      for (int i = 0; i < 30; i++) begin
        expV = (expV + 1) & 'hFFFF;
        if (expV == 20) begin
          m++;
          if (zret && eqie) expV = 0;
        end
      end
      waitc(60);
      rd(2'd1, c1);
      chk($sformatf("R5 count cfg%0d", cfg), c1 == expV, c1, expV);
      rd(2'd0, v);
      chk($sformatf("R4 flag cfg%0d", cfg), v[10] == (eqie && m > 0), v[10], int'(eqie && m > 0));
      chk($sformatf("R4 irq cfg%0d", cfg), irqCnt - base == (eqie ? m : 0), irqCnt - base, eqie ? m : 0);
    end

    // R11: compare equal to count does not match before a wrap
    wr(2'd0, 'hC00); wr(2'd1, 'hFFF0); wr(2'd2, 'hFFF0);
    rd(2'd1, v); chk("R11 count load", v == 'hFFF0, v, 'hFFF0);
    base = irqCnt;
    wr(2'd0, 'h180); waitc(20);
    rd(2'd0, v); chk("R11 no early match", v[10] == 1'b0, v[10], 0);
    chk("R11 no early irq", irqCnt == base, irqCnt - base, 0);
    // R11: compare below count matches after the wrap
    wr(2'd0, 'hC00); wr(2'd1, 'hFFFA); wr(2'd2, 3);
    base = irqCnt;
    wr(2'd0, 'h180); waitc(40);
    rd(2'd0, v); chk("R11 match after wrap", v[10] == 1'b1 && v[11] == 1'b1, v[11:10], 3);
    chk("R11 irq after wrap", irqCnt - base == 1, irqCnt - base, 1);

    // R7: enabling the gate clears and stops
    wr(2'd0, 'hC80); waitc(10);
    wr(2'd0, 'h8C);
    rd(2'd1, v); chk("R7 gate enable clears count", v == 0, v, 0);
    rd(2'd0, v); chk("R7 gate enable clears run", v[7] == 1'b0, v[7], 0);
    waitc(20);
    rd(2'd1, v); chk("R7 gated count stays", v == 0, v, 0);

    // R8: behaviour 0 counts only while gate low
    vblankIn = 1'b1; waitc(6);
    rd(2'd1, v); chk("R8 still stopped at start", v == 0, v, 0);
    vblankIn = 1'b0; waitc(6);
    rd(2'd1, c0); waitc(20); rd(2'd1, c1);
    chk("R8 runs after end", c1 - c0 == 10, c1 - c0, 10);
    vblankIn = 1'b1; waitc(6);
    rd(2'd1, c0); waitc(20); rd(2'd1, c1);
    chk("R8 pauses at start", c1 == c0, c1, c0);
    vblankIn = 1'b0; waitc(6);
    rd(2'd1, v); chk("R8 resumes no reset", v > c1, v, c1 + 1);

    // R9: behaviour 1
    wr(2'd0, 'h9C);
    vblankIn = 1'b1; waitc(6);
    rd(2'd1, v); chk("R9 b1 start resets", v <= 3 && v > 0, v, 2);
    waitc(40);
    vblankIn = 1'b0; waitc(6);
    rd(2'd1, v); chk("R9 b1 end keeps", v >= 20, v, 20);
    vblankIn = 1'b1; waitc(6);
    rd(2'd1, v); chk("R9 b1 restart", v <= 3, v, 2);
    vblankIn = 1'b0; waitc(3);

    // R9: behaviour 2
    wr(2'd0, 'hAC);
    vblankIn = 1'b1; waitc(10);
    rd(2'd1, v); chk("R9 b2 start ignored", v == 0, v, 0);
    vblankIn = 1'b0; waitc(6);
    rd(2'd1, v); chk("R9 b2 end starts", v <= 3 && v > 0, v, 2);
    waitc(40);
    vblankIn = 1'b1; waitc(6);
    rd(2'd1, v); chk("R9 b2 start keeps", v >= 20, v, 20);
    vblankIn = 1'b0; waitc(6);
    rd(2'd1, v); chk("R9 b2 end restarts", v <= 3, v, 2);

    // R9: behaviour 3
    wr(2'd0, 'hBC);
    vblankIn = 1'b1; waitc(6);
    rd(2'd1, v); chk("R9 b3 start resets", v <= 3 && v > 0, v, 2);
    waitc(40);
    vblankIn = 1'b0; waitc(6);
    rd(2'd1, v); chk("R9 b3 end resets", v <= 3, v, 2);

    // R7: horizontal-blank gate source, vertical blank ignored
    wr(2'd0, 'h94);
    hPulse();
    waitc(40);
    vblankIn = 1'b1; waitc(6); vblankIn = 1'b0; waitc(6);
    rd(2'd1, v); chk("R7 unselected source ignored", v >= 20, v, 20);
    hblankIn = 1'b1; waitc(6);
    rd(2'd1, v); chk("R7 hblank source resets", v <= 3, v, 2);
    hblankIn = 1'b0; waitc(3);

    // R10: the 0111 code turns the gate off
    wr(2'd0, 'hC00); wr(2'd1, 50);
    wr(2'd0, 'h87);
    rd(2'd1, v); chk("R10 no clear", v == 50, v, 50);
    rd(2'd0, v); chk("R10 run kept", v[7] == 1'b1, v[7], 1);
    for (int i = 0; i < 5; i++) hPulse();
    waitc(4);
    rd(2'd1, v); chk("R10 counts hblank", v == 55, v, 55);

    // R12: every pulse one clock wide
    chk("R12 pulse width", irqWide == 0, irqWide, 0);
    chk("R12 pulses seen", irqCnt > 0, irqCnt, 1);

    finish();
  end
endmodule